// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by fetching one entry from each level of a three-level page table in memory. A translation cache hands it the address of a page it missed on. The walker forms the first entry address from a table base register, then follows the entry it reads to the next table, and so on down to a leaf. The leaf supplies the physical page number, which is joined to the untouched page offset. If any entry fetched on the way is not marked valid, the walk stops there and returns a page-fault response.

The virtual page number is the upper 20 bits of the address. It is cut into three index fields, one per level: bits [31:25], [24:18] and [17:12]. Entries are 32-bit words, so each index is scaled by four before it is added to a table address. Bit 31 of every entry is its valid flag, and the low bits carry the next table's byte address or the leaf's page number. The walker keeps at most one memory read in flight. It takes a new request only when it is idle. Only a kernel-mode write can change the base register.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle. `req_ready` is 1, `mem_rd_en` is 0, `rsp_valid` is 0, and the table base register holds 0.
- R2: A request is taken only in a cycle where `req_valid` and `req_ready` are both 1. `req_valid` asserted while a walk is running has no effect on the reads issued or on the response returned.
- R3: The first read of a walk goes to base + 4 × va[31:25].
- R4: The second and third reads go to P + 4 × va[24:18] and P + 4 × va[17:12], where P is the entry returned by the previous read with bit 31 forced to 0.
- R5: Each level issues exactly one single-cycle `mem_rd_en` pulse. The first pulse comes in the cycle after the request is taken. Each later pulse comes in the cycle after the previous level's `mem_rd_valid` beat, and never before it.
- R6: When all three entries are valid, the response has `rsp_fault`=0, `rsp_vpn`=va[31:12], `rsp_ppn`=leaf[17:0] (leaf bits 30:18 are ignored) and `rsp_paddr`={leaf[17:0], va[11:0]}, 30 bits wide.
- R7: An entry read with bit 31 = 0 at any level ends the walk. No further read is issued, and the response carries `rsp_fault`=1, `rsp_ppn`=0 and `rsp_paddr`=0.
- R8: `rsp_valid` is a one-cycle pulse in the cycle after the final read data beat. `req_ready` returns to 1 in the following cycle.
- R9: The base register loads `cfg_base` only when `cfg_we` and `cfg_kernel` are both 1. A write with `cfg_kernel`=0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Base register write strobe |
| cfg_kernel | input | 1 | Writer is in kernel mode |
| cfg_base | input | 32 | New table base byte address |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Walk hit an invalid entry |
| rsp_vpn | output | 20 | Virtual page number of the walk |
| rsp_ppn | output | 18 | Physical page number (0 on fault) |
| rsp_paddr | output | 30 | Physical address (0 on fault) |
| mem_rd_en | output | 1 | Memory read request pulse |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rd_valid | input | 1 | Read data beat |
| mem_rd_data | input | 32 | Entry word returned |

## Verification
The bench varies memory latency between one and three cycles. A walker that advanced on a timer rather than on the data beat would then issue reads early or twice. Faults are forced separately at each of the three levels. A design that kept walking past an invalid entry would show an extra read, and one that tested the wrong bit would return a translation instead of a fault. Leaf entries carry junk in bits 30:18, and pointer entries carry their valid flag in bit 31, so a walker that failed to mask either would produce a wrong page number or a wrong next address. The bench also sends a stray request in the middle of a walk, writes the base register in user mode, and then writes it again in kernel mode. A walker that accepted the stray request or took the user-mode base would read from the wrong addresses.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_L1    = 3'd1,
    ST_L2    = 3'd2,
    ST_L3    = 3'd3,
    ST_DONE  = 3'd4,
    ST_FAULT = 3'd5
  } walk_st_e;

endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         kernel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] base
);

  logic         load;
  logic [W-1:0] base_q;

  assign load = wr_en & kernel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (load) begin
      base_q <= wdata;
    end
  end

  assign base = base_q;

  AST_BASE_USER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !kernel) |=> $stable(base)); // R9

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int MA_W   = 32,
  parameter int L1_W   = 7,
  parameter int L2_W   = 7,
  parameter int L3_W   = 6,
  parameter int ENT_SH = 2
) (
  input  logic [L1_W+L2_W+L3_W-1:0] vpn,
  input  logic [1:0]                lvl,
  input  logic [MA_W-1:0]           base,
  input  logic [MA_W-1:0]           ptr,
  output logic [MA_W-1:0]           addr
);

  localparam int VPN_W = L1_W + L2_W + L3_W;

  logic [MA_W-1:0] scaled [3];
  logic [MA_W-1:0] table_base;

  for (genvar g = 0; g < 3; g++) begin : g_lvl
    localparam int FW  = (g == 0) ? L1_W : (g == 1) ? L2_W : L3_W;
    localparam int LSB = (g == 0) ? (L2_W + L3_W) : (g == 1) ? L3_W : 0;
    logic [FW-1:0] field;
    assign field     = vpn[LSB +: FW];
    assign scaled[g] = {{(MA_W-FW){1'b0}}, field} << ENT_SH;
  end

  assign table_base = (lvl == 2'd0) ? base : ptr;

  always_comb begin
    case (lvl)
      2'd1:    addr = table_base + scaled[1];
      2'd2:    addr = table_base + scaled[2];
      default: addr = table_base + scaled[0];
    endcase
  end

  initial begin
    assert (VPN_W <= MA_W) else $error("vpn wider than memory address");
  end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int L1_W  = 7,
  parameter int L2_W  = 7,
  parameter int L3_W  = 6,
  parameter int PPN_W = 18,
  parameter int ENT_W = 32,
  parameter int MA_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic                     cfg_kernel,
  input  logic [MA_W-1:0]          cfg_base,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [VA_W-1:0]          req_vaddr,
  output logic                     rsp_valid,
  output logic                     rsp_fault,
  output logic [VA_W-OFF_W-1:0]    rsp_vpn,
  output logic [PPN_W-1:0]         rsp_ppn,
  output logic [PPN_W+OFF_W-1:0]   rsp_paddr,
  output logic                     mem_rd_en,
  output logic [MA_W-1:0]          mem_rd_addr,
  input  logic                     mem_rd_valid,
  input  logic [ENT_W-1:0]         mem_rd_data
);

  localparam int VPN_W   = VA_W - OFF_W;
  localparam int PA_W    = PPN_W + OFF_W;
  localparam int VLD_BIT = ENT_W - 1;
  localparam logic [ENT_W-1:0] PTR_MASK = ~({{(ENT_W-1){1'b0}}, 1'b1} << VLD_BIT);

  walk_st_e          st_q, st_d;
  logic              rd_pend_q, rd_pend_d;
  logic [VA_W-1:0]   va_q;
  logic [MA_W-1:0]   ptr_q, ptr_d;
  logic [PPN_W-1:0]  ppn_q, ppn_d;
  logic              ptr_en, ppn_en, va_en;
  logic              accept, in_walk, entry_ok;
  logic [1:0]        lvl;
  logic [MA_W-1:0]   base;
  logic [ENT_W-1:0]  masked;

  ptw_base_reg #(.W(MA_W)) u_base (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_we),
    .kernel (cfg_kernel),
    .wdata  (cfg_base),
    .base   (base)
  );

  ptw_addr_gen #(
    .MA_W  (MA_W),
    .L1_W  (L1_W),
    .L2_W  (L2_W),
    .L3_W  (L3_W),
    .ENT_SH(2)
  ) u_addr (
    .vpn  (va_q[VA_W-1:OFF_W]),
    .lvl  (lvl),
    .base (base),
    .ptr  (ptr_q),
    .addr (mem_rd_addr)
  );

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_ready & req_valid;
  assign va_en     = accept;
  assign in_walk   = (st_q == ST_L1) | (st_q == ST_L2) | (st_q == ST_L3);
  assign entry_ok  = mem_rd_data[VLD_BIT];
  assign masked    = mem_rd_data & PTR_MASK;
  assign ptr_d     = MA_W'(masked);

  always_comb begin
    case (st_q)
      ST_L2:   lvl = 2'd1;
      ST_L3:   lvl = 2'd2;
      default: lvl = 2'd0;
    endcase
  end

  // next-state and enables
  always_comb begin
    st_d      = st_q;
    rd_pend_d = rd_pend_q;
    ptr_en    = 1'b0;
    ppn_en    = 1'b0;
    ppn_d     = ppn_q;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d      = ST_L1;
          rd_pend_d = 1'b0;
        end
      end
      ST_L1, ST_L2, ST_L3: begin
        if (!rd_pend_q) begin
          rd_pend_d = 1'b1;
        end else if (mem_rd_valid) begin
          rd_pend_d = 1'b0;
          if (!entry_ok) begin
            st_d   = ST_FAULT;
            ppn_en = 1'b1;
            ppn_d  = '0;
          end else if (st_q == ST_L3) begin
            st_d   = ST_DONE;
            ppn_en = 1'b1;
            ppn_d  = mem_rd_data[PPN_W-1:0];
          end else begin
            st_d   = (st_q == ST_L1) ? ST_L2 : ST_L3;
            ptr_en = 1'b1;
          end
        end
      end
      ST_DONE, ST_FAULT: st_d = ST_IDLE;
      default:           st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      rd_pend_q <= 1'b0;
      va_q      <= '0;
      ptr_q     <= '0;
      ppn_q     <= '0;
    end else begin
      st_q      <= st_d;
      rd_pend_q <= rd_pend_d;
      if (va_en)  va_q  <= req_vaddr;
      if (ptr_en) ptr_q <= ptr_d;
      if (ppn_en) ppn_q <= ppn_d;
    end
  end

  assign mem_rd_en = in_walk & ~rd_pend_q;
  assign rsp_valid = (st_q == ST_DONE) | (st_q == ST_FAULT);
  assign rsp_fault = (st_q == ST_FAULT);
  assign rsp_vpn   = va_q[VA_W-1:OFF_W];
  assign rsp_ppn   = ppn_q;
  assign rsp_paddr = rsp_fault ? '0 : {ppn_q, va_q[OFF_W-1:0]};

  initial begin
    assert (VPN_W == L1_W + L2_W + L3_W) else $error("index fields do not cover vpn");
    assert (PA_W <= MA_W) else $error("physical address wider than memory address");
  end

  AST_SINGLE_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_rd_en && !rsp_valid)); // R2
  AST_VPN_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(rsp_vpn)); // R2
  AST_RSP_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(mem_rd_valid)); // R8
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready)); // R8
  AST_FAULT_NO_PPN: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_ppn == '0)); // R7

endmodule

// File: tb/ptw_walker_test.sv
module ptw_walker_test;

  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        cfg_we, cfg_kernel;
  logic [31:0] cfg_base;
  logic        req_valid, req_ready;
  logic [31:0] req_vaddr;
  logic        rsp_valid, rsp_fault;
  logic [19:0] rsp_vpn;
  logic [17:0] rsp_ppn;
  logic [29:0] rsp_paddr;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid;
  logic [31:0] mem_rd_data;

  ptw_walker uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_kernel(cfg_kernel), .cfg_base(cfg_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_vpn(rsp_vpn),
    .rsp_ppn(rsp_ppn), .rsp_paddr(rsp_paddr),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // sparse table memory
  logic [31:0] mem [logic [31:0]];
  logic [31:0] nxt_tbl = 32'h0010_0000;

  // reference model state
  logic [31:0] base_m = 32'h0;
  logic [31:0] exp_q [$];
  bit          exp_fault;
  logic [17:0] exp_ppn;
  logic [31:0] exp_va;
  bit          exp_ready = 1;
  bit          rd_due = 0, rsp_due = 0;
  int          rd_idx = 0;
  int          lat = 1;
  int          cnt = 0;
  bit          pend = 0, pend_last = 0;
  logic [31:0] pend_data;
  int          walks_done = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic map(input logic [31:0] b, input logic [31:0] va, input logic [17:0] ppn,
                     input logic [12:0] junk, output logic [31:0] leaf_a);
    logic [31:0] a, t;
    t = b;
    for (int l = 0; l < 2; l++) begin
      a = t + ((l == 0) ? {25'b0, va[31:25]} << 2 : {25'b0, va[24:18]} << 2);
      if (!rd(a)[31]) begin
        mem[a] = {1'b1, nxt_tbl[30:0]};
        nxt_tbl = nxt_tbl + 32'h200;
      end
      t = {1'b0, mem[a][30:0]};
    end
    leaf_a = t + ({26'b0, va[17:12]} << 2);
    mem[leaf_a] = {1'b1, junk, ppn};
  endtask

  task automatic build_model(input logic [31:0] va);
    logic [31:0] cur, a, e;
    logic [6:0]  idx;
    exp_q.delete();
    exp_va = va;
    cur = base_m;
    e = 32'h0;
    for (int l = 0; l < 3; l++) begin
      idx = (l == 0) ? va[31:25] : (l == 1) ? va[24:18] : {1'b0, va[17:12]};
      a = cur + ({25'b0, idx} << 2);
      exp_q.push_back(a);
      e = rd(a);
      if (!e[31]) begin
        exp_fault = 1;
        exp_ppn   = '0;
        return;
      end
      cur = {1'b0, e[30:0]};
    end
    exp_fault = 0;
    exp_ppn   = e[17:0];
  endtask

  // monitor, reference model and memory responder
  initial begin
    bit due_now, rdd_now, accept;
    logic [31:0] ea;
    mem_rd_valid = 0;
    mem_rd_data  = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        due_now = rsp_due; rsp_due = 0;
        rdd_now = rd_due;  rd_due  = 0;
        chk(req_ready == exp_ready, "R2 req_ready", req_ready, exp_ready);
        chk(rsp_valid == due_now, "R8 rsp_valid timing", rsp_valid, due_now);
        chk(mem_rd_en == rdd_now, "R5 read pulse timing", mem_rd_en, rdd_now);
        if (rsp_valid && due_now) begin
          chk(rsp_fault == exp_fault, exp_fault ? "R7 fault flag" : "R6 fault flag", rsp_fault, exp_fault);
          chk(rsp_vpn == exp_va[31:12], "R6 vpn", rsp_vpn, exp_va[31:12]);
          chk(rsp_ppn == exp_ppn, exp_fault ? "R7 ppn" : "R6 ppn", rsp_ppn, exp_ppn);
          chk(rsp_paddr == (exp_fault ? 30'h0 : {exp_ppn, exp_va[11:0]}),
              exp_fault ? "R7 paddr" : "R6 paddr", rsp_paddr,
              exp_fault ? 30'h0 : {exp_ppn, exp_va[11:0]});
        end
        // memory data beat
        mem_rd_valid = 0;
        if (pend) begin
          cnt--;
          if (cnt == 0) begin
            mem_rd_valid = 1;
            mem_rd_data  = pend_data;
            pend = 0;
            if (pend_last) rsp_due = 1; else rd_due = 1;
          end
        end
        if (mem_rd_en) begin
          chk(!pend, "R5 read while pending", 1, 0);
          if (exp_q.size() == 0) begin
            chk(0, "R7 read after walk end", mem_rd_addr, 0);
          end else begin
            ea = exp_q.pop_front();
            if (rd_idx == 0) chk(mem_rd_addr == ea, "R3 level-1 address", mem_rd_addr, ea);
            else             chk(mem_rd_addr == ea, "R4 next-level address", mem_rd_addr, ea);
          end
          rd_idx++;
          pend = 1; cnt = lat; pend_data = rd(mem_rd_addr);
          pend_last = (exp_q.size() == 0);
        end
        // model handshake
        accept = req_valid && exp_ready;
        if (due_now) begin
          exp_ready = 1;
          walks_done++;
        end
        if (accept) begin
          build_model(req_vaddr);
          exp_ready = 0;
          rd_due = 1;
          rd_idx = 0;
        end
        if (cfg_we && cfg_kernel) base_m = cfg_base;
      end
    end
  end

  task automatic do_cfg(input bit kern, input logic [31:0] v);
    @(posedge clk); #1;
    cfg_we = 1; cfg_kernel = kern; cfg_base = v;
    @(posedge clk); #1;
    cfg_we = 0; cfg_kernel = 0;
  endtask

  task automatic do_walk(input logic [31:0] va, input int l, input bit stray);
    int target;
    target = walks_done + 1;
    lat = l;
    @(posedge clk); #1;
    req_valid = 1; req_vaddr = va;
    @(posedge clk); #1;
    req_valid = 0;
    if (stray) begin
      @(posedge clk); #1;
      req_valid = 1; req_vaddr = ~va;
      repeat (2) @(posedge clk);
      #1 req_valid = 0;
    end
    while (walks_done < target) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] la;
    rst_n = 0; cfg_we = 0; cfg_kernel = 0; cfg_base = '0;
    req_valid = 0; req_vaddr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(req_ready == 1, "R1 ready after reset", req_ready, 1);
    chk(mem_rd_en == 0, "R1 no read after reset", mem_rd_en, 0);
    chk(rsp_valid == 0, "R1 no response after reset", rsp_valid, 0);

    // R1/R9: base resets to 0, first read at 4*idx, empty memory faults (R7)
    do_walk(32'h2400_0123, 1, 0);

    map(32'h0004_0000, 32'h0000_0ABC, 18'h12345, 13'h0000, la);
    map(32'h0004_0000, 32'hFFFF_FFFF, 18'h3FFFF, 13'h1FFF, la);
    map(32'h0004_0000, 32'h8642_1000, 18'h00001, 13'h0A5A, la);
    map(32'h0004_0000, 32'h8642_2000, 18'h2AAAA, 13'h1555, la);
    map(32'h0004_0000, 32'h8642_6000, 18'h1F0F0, 13'h0000, la);
    mem[la] = mem[la] & 32'h7FFF_FFFF;  // R7: leaf invalid but with nonzero ppn

    do_cfg(1, 32'h0004_0000);                 // R9 kernel load
    do_walk(32'h0000_0ABC, 1, 0);             // R3 R4 R6
    do_walk(32'hFFFF_FFFF, 2, 0);             // R6 junk in leaf bits 30:18
    do_walk(32'h8642_1FFF, 3, 0);             // R6 max offset, slow memory
    do_walk(32'h8642_2000, 1, 0);             // R4 shared upper tables
    do_walk(32'h8650_0000, 2, 0);             // R7 fault at level 2
    do_walk(32'h8642_5000, 1, 0);             // R7 fault at level 3 (empty)
    do_walk(32'h8642_6000, 3, 0);             // R7 fault at level 3 (invalid leaf)
    do_walk(32'h1000_0000, 1, 0);             // R7 fault at level 1
    do_cfg(0, 32'h0009_0000);                 // R9 user write ignored
    do_walk(32'h0000_0ABC, 2, 0);             // R9 old base still used
    do_cfg(1, 32'h0009_0000);                 // R9 kernel write takes
    do_walk(32'h0000_0ABC, 1, 0);             // R3 new base, R7 fault
    do_cfg(1, 32'h0004_0000);
    do_walk(32'hFFFF_FFFF, 3, 1);             // R2 stray request ignored
    do_walk(32'h8642_1000, 1, 0);             // R2 next request after stray

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule